// File: doc/BRIEF.md
# Gated Edge-Counting Frequency Meter

This block measures the frequency of several digital inputs at once by counting rising edges over each sampling period. A sampling period ends when an external sample strobe arrives, so frequency channels can share one sample stream with other kinds of channels. Host traffic, averaging and the conversion to hertz happen elsewhere.

The input pins are split into port groups. Each group routes one chosen pin to its own channel, so there is one independent channel per group. Each channel has a down-counter that starts at its all-ones preload, and every qualified rising edge takes one off it. When a strobe arrives, the block freezes all channels. It lets one idle cycle pass so that no decrement is in flight, and then reads each count as the preload minus the remaining value. It publishes the counts with a one-cycle valid pulse, reloads the counters and resumes counting. An edge that lands inside the freeze window is held as pending and charged to the next period, so it is not lost.

Top module: `edge_freq_meter`

## Requirements
- R1: After reset, `count_valid` is 0 and every channel's count and overflow flag read 0.
- R2: Each `count` field (CW bits, channel i at bits i*CW and up) equals the number of rising edges seen on the selected pin of channel i since the previous sample. The value is formed as the all-ones preload minus the remaining counter value.
- R3: Falling edges never change a count. A pin that only falls during a period reports 0.
- R4: `count_valid` goes high for exactly one cycle, three cycles after the cycle in which an accepted `sample_stb` was high. A strobe that arrives while a sample is still being taken (the two cycles after an accepted strobe) is ignored.
- R5: Counting is frozen for the two cycles after an accepted strobe. A rising edge detected in that window is not in the current sample and is counted in the next one.
- R6: Within a group of PINS pins, only the pin whose index is given by that group's `pin_sel` field (SW = clog2(PINS) bits, group i at bits i*SW and up) is counted. The other pins of the group have no effect.
- R7: Channels count independently of one another. The number of channels equals the number of port groups, NCH (3 by default).
- R8: Once a counter reaches zero, further edges leave it at zero and set the channel's overflow flag. That sample then reports count = preload with `ovf` = 1, and the flag is clear again in the next sample.
- R9: A channel whose `ch_en` bit is 0 counts nothing. Its `pin_sel` field is taken only while it is disabled, and a new value resets its counter to the preload. While the channel is enabled, `pin_sel` changes are ignored.
- R10: After each read the counters restart from the preload, so each sample reports only its own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NCH*PINS | Asynchronous digital inputs, grouped PINS per channel |
| pin_sel | input | NCH*SW | Per-group pin index |
| ch_en | input | NCH | Per-channel count enable |
| sample_stb | input | 1 | End-of-period strobe |
| count | output | NCH*CW | Per-channel edge count of the last sample |
| ovf | output | NCH | Per-channel overflow flag of the last sample |
| count_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
A pin change reaches the counter two cycles later, through the two synchronizer flops, and is decremented at the end of that cycle. The bench therefore holds the pins quiet for five cycles before it raises a strobe, which makes the expected count exact. Counts and `count_valid` are due in the third cycle after the strobe cycle. The bench samples them at the falling edge of that cycle and checks that `count_valid` has dropped one cycle later. For the freeze-window case, a pin is raised in the strobe cycle itself, so its edge lands two cycles later, inside the freeze. It is then expected in the following sample and not in the current one.

// File: rtl/edge_freq_meter.sv
module edge_freq_meter #(
  parameter int NCH  = 3,
  parameter int PINS = 8,
  parameter int CW   = 20
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NCH*PINS-1:0]            pin_in,
  input  logic [NCH*$clog2(PINS)-1:0]    pin_sel,
  input  logic [NCH-1:0]                 ch_en,
  input  logic                           sample_stb,
  output logic [NCH*CW-1:0]              count,
  output logic [NCH-1:0]                 ovf,
  output logic                           count_valid
);
  localparam int SW = $clog2(PINS);
  localparam logic [CW-1:0] PRE = {CW{1'b1}};

  logic [NCH*PINS-1:0] sync1, sync2;
  logic [1:0] ph;
  wire frz = ph != 2'd0;
  wire rd  = ph == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      ph <= 2'd0;
      count_valid <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      count_valid <= rd;
      case (ph)
        2'd0:    if (sample_stb) ph <= 2'd1;
        2'd1:    ph <= 2'd2;
        default: ph <= 2'd0;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [SW-1:0] sel_q;
    logic          prev, pend, sat;
    logic [CW-1:0] cnt;
    wire [PINS-1:0] grp = sync2[g*PINS +: PINS];
    wire [SW-1:0]   sel_in = pin_sel[g*SW +: SW];
    wire cur    = grp[sel_q];
    wire rise   = cur & ~prev & ch_en[g];
    wire selchg = !ch_en[g] && (sel_in != sel_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q <= '0;
        prev  <= 1'b0;
        pend  <= 1'b0;
        sat   <= 1'b0;
        cnt   <= PRE;
        count[g*CW +: CW] <= '0;
        ovf[g] <= 1'b0;
      end else begin
        prev <= cur;
        if (rd) begin
          count[g*CW +: CW] <= PRE - cnt;
          ovf[g] <= sat;
        end
        if (selchg) begin
          sel_q <= sel_in;
          cnt   <= PRE;
          sat   <= 1'b0;
          pend  <= 1'b0;
        end else if (rd) begin
          cnt  <= PRE - CW'(pend | rise);
          sat  <= 1'b0;
          pend <= 1'b0;
        end else if (frz) begin
          pend <= pend | rise;
        end else if (rise) begin
          if (cnt == '0) sat <= 1'b1;
          else cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

module edge_freq_meter_chk #(
  parameter int NCH = 3,
  parameter int CW  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_stb,
  input logic              count_valid,
  input logic [NCH*CW-1:0] count,
  input logic [NCH-1:0]    ovf,
  input logic [1:0]        ph
);
  // R4
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_valid |-> $past(sample_stb, 3));
  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_valid |=> !count_valid);
  // R5
  freeze_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd1) |=> (ph == 2'd2));
  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> count_valid);
  for (genvar i = 0; i < NCH; i++) begin : g_ovf
    // R8
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_valid && ovf[i]) |-> (count[i*CW +: CW] == {CW{1'b1}}));
  end
endmodule

bind edge_freq_meter edge_freq_meter_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
  .count_valid(count_valid), .count(count), .ovf(ovf), .ph(ph)
);

// File: tb/edge_freq_meter_tb_top.sv
module edge_freq_meter_tb_top;
  localparam int NCH = 3, PINS = 8, CW = 10, SW = 3;
  localparam int PRE = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, sample_stb = 0;
  logic [NCH*PINS-1:0] pin_in = '0;
  logic [NCH*SW-1:0]   pin_sel = '0;
  logic [NCH-1:0]      ch_en = '0;
  logic [NCH*CW-1:0]   count;
  logic [NCH-1:0]      ovf;
  logic                count_valid;

  int tests = 0, fails = 0;
  int cnt_m [NCH];
  int sel_m [NCH];
  bit done = 0;

  always #4 clk = ~clk;

  edge_freq_meter #(.NCH(NCH), .PINS(PINS), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sel(pin_sel),
    .ch_en(ch_en), .sample_stb(sample_stb), .count(count), .ovf(ovf),
    .count_valid(count_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic [NCH*PINS-1:0] v);
    for (int c = 0; c < NCH; c++) begin
      int b = c*PINS + sel_m[c];
      if (ch_en[c] && v[b] && !pin_in[b]) cnt_m[c]++;
    end
    pin_in = v;
    @(negedge clk);
  endtask

  task automatic set_sel(input int c, input int s);
    ch_en[c] = 1'b0;
    pin_sel[c*SW +: SW] = SW'(s);
    if (s != sel_m[c]) cnt_m[c] = 0;
    sel_m[c] = s;
    idle(3);
    ch_en[c] = 1'b1;
    @(negedge clk);
  endtask

  task automatic sample(input string req);
    sample_stb = 1;
    @(negedge clk);
    sample_stb = 0;
    idle(2);
    chk(count_valid === 1'b1, "R4 valid due", int'(count_valid), 1);
    for (int c = 0; c < NCH; c++) begin
      int e = (cnt_m[c] > PRE) ? PRE : cnt_m[c];
      chk(int'(count[c*CW +: CW]) == e, req, int'(count[c*CW +: CW]), e);
      chk(ovf[c] == (cnt_m[c] > PRE), "R8 ovf flag", int'(ovf[c]), int'(cnt_m[c] > PRE));
      cnt_m[c] = 0;
    end
    @(negedge clk);
    chk(count_valid === 1'b0, "R4 single pulse", int'(count_valid), 0);
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    for (int c = 0; c < NCH; c++) begin cnt_m[c] = 0; sel_m[c] = 0; end
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk(count_valid === 1'b0, "R1 valid", int'(count_valid), 0);
    chk(count === '0, "R1 count", int'(count[CW-1:0]), 0);
    chk(ovf === '0, "R1 ovf", int'(ovf), 0);
    ch_en = '1;
    idle(3);

    // R2 R6 R7 R10: random patterns with random pin selection
    for (int it = 0; it < 30; it++) begin
      if (it % 3 == 0)
        for (int c = 0; c < NCH; c++) set_sel(c, int'($urandom_range(PINS-1)));
      for (int k = 0, n = int'($urandom_range(60, 5)); k < n; k++)
        drive(NCH*PINS'($urandom));
      idle(5);
      sample("R2 R6 R7 random count");
    end

    // R3: only falling edges
    drive('1); idle(5); sample("R10 prep");
    drive('0); idle(5);
    sample("R3 falling ignored");

    // R5: edge detected inside freeze window lands in next sample
    sample_stb = 1;
    pin_in[0*PINS + sel_m[0]] = 1'b1;
    @(negedge clk);
    sample_stb = 0;
    idle(2);
    chk(int'(count[CW-1:0]) == 0, "R5 freeze excluded", int'(count[CW-1:0]), 0);
    idle(6);
    cnt_m[0] = 1; cnt_m[1] = 0; cnt_m[2] = 0;
    sample("R5 pending counted next");

    // R4: strobe held three cycles gives one valid only
    sample_stb = 1; idle(3); sample_stb = 0;
    chk(count_valid === 1'b1, "R4 held strobe valid", int'(count_valid), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(count_valid === 1'b0, "R4 ignored strobe", int'(count_valid), 0);
    end

    // R8: overflow and recovery
    pin_in = '0; idle(4);
    for (int c = 0; c < NCH; c++) cnt_m[c] = 0;
    for (int k = 0; k < 1100; k++) begin
      drive(pin_in ^ NCH*PINS'(1) << sel_m[0]);
      drive(pin_in ^ NCH*PINS'(1) << sel_m[0]);
    end
    idle(5);
    sample("R8 saturated count");
    idle(2);
    sample("R8 cleared next");

    // R9: disabled channel ignores edges; enabled channel ignores pin_sel
    ch_en[1] = 0; idle(2);
    for (int k = 0; k < 10; k++) drive(pin_in ^ NCH*PINS'(1) << (PINS + sel_m[1]));
    idle(5);
    sample("R9 disabled no count");
    ch_en[1] = 1; idle(2);
    pin_sel[2*SW +: SW] = SW'(sel_m[2] ^ 1);
    for (int k = 0; k < 12; k++) begin
      drive(pin_in ^ NCH*PINS'(1) << (2*PINS + sel_m[2]));
      drive(pin_in ^ NCH*PINS'(1) << (2*PINS + (sel_m[2] ^ 1)));
    end
    idle(5);
    sample("R9 sel ignored while enabled");
    pin_sel[2*SW +: SW] = SW'(sel_m[2]);
    // R9: sel change while disabled resets counter
    for (int k = 0; k < 8; k++) drive(pin_in ^ NCH*PINS'(1) << (2*PINS + sel_m[2]));
    idle(3);
    set_sel(2, sel_m[2] ^ 2);
    idle(5);
    sample("R9 sel change resets count");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule